// File: doc/BRIEF.md
# Host-to-DSP Doorbell Mailbox

This register block lets a host processor ring a doorbell toward a DSP and pass a small parameter word with it. The host writes a command byte to its doorbell register. That write raises an interrupt status bit on the DSP side and sets a busy flag that the host can poll. Before ringing, the host can load a multi-byte control word, one byte per host address. The DSP reads the control word as a single wide register.

On the DSP side, the interrupt output is the status bit gated by an enable bit. When the DSP reads its doorbell register, it gets the command byte back, and the status clears as a side effect of that read. The busy flag is released separately. The DSP writes 0 to it when it is ready for the next doorbell, so the busy flag and the status bit can drop at different times. Both ports are simple synchronous register ports on one clock. Read data is registered and appears on the cycle after the read strobe.

Top module: `h2d_mbox`

## Requirements
- R1: A host write to host address 0 sets the interrupt status on the next clock edge. `dsp_irq_o` is 1 from that edge on if the enable bit is 1.
- R2: A host write to host address 0 sets the busy flag. A host read of address 0 returns the busy flag in bit 0, with all other bits 0.
- R3: A DSP read of DSP address 0 returns the last command byte the host wrote, zero-extended. The same read clears the interrupt status.
- R4: The busy flag takes bit 0 of a DSP write to DSP address 2. Clearing the interrupt status by a DSP read does not change the busy flag.
- R5: `dsp_irq_o` is the status AND the enable bit. A DSP write to DSP address 1 loads the enable bit from bit 1. A DSP read of address 1 returns the status in bit 0 and the enable bit in bit 1. Masking hides the interrupt but keeps the status.
- R6: Host addresses 1 and 2 hold the low and high bytes of the control word. The host can read them back, and a DSP read of DSP address 3 returns the full 16-bit word.
- R7: If a host doorbell write and a DSP read of DSP address 0 happen in the same cycle, the status stays set.
- R8: Reset gives enable 0, status 0, busy 0, `dsp_irq_o` 0, and zero read data, command byte and control word.
- R9: Read data is registered. It is valid the cycle after the read strobe and holds its value while no read is issued.
- R10: If a host doorbell write and a DSP write of 0 to the busy flag happen in the same cycle, busy stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_we_i | input | 1 | Host write strobe |
| host_re_i | input | 1 | Host read strobe |
| host_addr_i | input | 2 | Host register address |
| host_wdata_i | input | 8 | Host write data |
| host_rdata_o | output | 8 | Host read data, registered |
| dsp_we_i | input | 1 | DSP write strobe |
| dsp_re_i | input | 1 | DSP read strobe |
| dsp_addr_i | input | 2 | DSP register address |
| dsp_wdata_i | input | 16 | DSP write data |
| dsp_rdata_o | output | 16 | DSP read data, registered |
| dsp_irq_o | output | 1 | Interrupt request to the DSP |

## Verification
Every state change lands on the first clock edge after the strobe, and each read result appears one register stage later. The interrupt output is a combinational AND of two flops, so it changes on the same edge as the write that moves either flop. The bench drives each step after a falling edge, lets one rising edge pass, and compares all three outputs at the next falling edge. Expected values in the step table therefore describe the state just after that single edge, including the held read data of steps that issue no read.

// File: rtl/h2d_mbox_pkg.sv
package h2d_mbox_pkg;
  localparam int HOST_W_DEF     = 8;
  localparam int CTRL_BYTES_DEF = 2;
  // host map: doorbell, then control bytes low to high
  localparam int HA_DOORBELL  = 0;
  localparam int HA_CTRL_BASE = 1;
  // dsp map
  localparam logic [1:0] DA_DOORBELL = 2'd0;
  localparam logic [1:0] DA_IRQ      = 2'd1;
  localparam logic [1:0] DA_BUSY     = 2'd2;
  localparam logic [1:0] DA_CTRL     = 2'd3;
  localparam int IRQ_STAT_BIT = 0;
  localparam int IRQ_EN_BIT   = 1;
  localparam int BUSY_BIT     = 0;
endpackage

// File: rtl/mbox_host_if.sv
module mbox_host_if
  import h2d_mbox_pkg::*;
#(
  parameter int HOST_W     = 8,
  parameter int CTRL_BYTES = 2,
  parameter int ADDR_W     = 2,
  localparam int CTRL_W    = HOST_W * CTRL_BYTES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [HOST_W-1:0] wdata_i,
  input  logic              busy_i,
  output logic              ring_o,
  output logic [HOST_W-1:0] cmd_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [HOST_W-1:0] rdata_o
);
  logic [HOST_W-1:0] rd_mux;

  assign ring_o = we_i && (addr_i == ADDR_W'(HA_DOORBELL));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cmd_o <= '0;
    else if (ring_o) cmd_o <= wdata_i;
  end

  for (genvar g = 0; g < CTRL_BYTES; g++) begin : g_ctrl
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        ctrl_o[g*HOST_W +: HOST_W] <= '0;
      else if (we_i && addr_i == ADDR_W'(HA_CTRL_BASE + g))
        ctrl_o[g*HOST_W +: HOST_W] <= wdata_i;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (addr_i == ADDR_W'(HA_DOORBELL)) rd_mux[BUSY_BIT] = busy_i;
    for (int i = 0; i < CTRL_BYTES; i++)
      if (addr_i == ADDR_W'(HA_CTRL_BASE + i)) rd_mux = ctrl_o[i*HOST_W +: HOST_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= rd_mux;
  end

  // control word only moves on a host write
  assert_ctrl_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(ctrl_o));
  assert_rdata_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o));
endmodule

// File: rtl/mbox_irq_core.sv
module mbox_irq_core (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ring_i,
  input  logic clr_i,
  input  logic en_we_i,
  input  logic en_d_i,
  input  logic busy_we_i,
  input  logic busy_d_i,
  output logic status_o,
  output logic en_o,
  output logic busy_o,
  output logic irq_o
);
  // set beats clear on a collision
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     status_o <= 1'b0;
    else if (ring_i) status_o <= 1'b1;
    else if (clr_i)  status_o <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        busy_o <= 1'b0;
    else if (ring_i)    busy_o <= 1'b1;
    else if (busy_we_i) busy_o <= busy_d_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_o <= 1'b0;
    else if (en_we_i) en_o <= en_d_i;
  end

  assign irq_o = status_o & en_o;

  assert_ring_sets_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ring_i |=> status_o && busy_o);
  assert_read_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !ring_i) |=> !status_o);
  assert_busy_release_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(busy_we_i && !busy_d_i && !ring_i));
  assert_mask_keeps_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ring_i && !clr_i) |=> $stable(status_o));
endmodule

// File: rtl/h2d_mbox.sv
module h2d_mbox
  import h2d_mbox_pkg::*;
#(
  parameter int HOST_W     = HOST_W_DEF,
  parameter int CTRL_BYTES = CTRL_BYTES_DEF,
  localparam int CTRL_W    = HOST_W * CTRL_BYTES,
  localparam int DSP_W     = CTRL_W,
  localparam int HOST_AW   = $clog2(CTRL_BYTES + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               host_we_i,
  input  logic               host_re_i,
  input  logic [HOST_AW-1:0] host_addr_i,
  input  logic [HOST_W-1:0]  host_wdata_i,
  output logic [HOST_W-1:0]  host_rdata_o,
  input  logic               dsp_we_i,
  input  logic               dsp_re_i,
  input  logic [1:0]         dsp_addr_i,
  input  logic [DSP_W-1:0]   dsp_wdata_i,
  output logic [DSP_W-1:0]   dsp_rdata_o,
  output logic               dsp_irq_o
);
  logic              ring, status, en, busy;
  logic [HOST_W-1:0] cmd;
  logic [CTRL_W-1:0] ctrl;
  logic [DSP_W-1:0]  d_mux;

  mbox_host_if #(.HOST_W(HOST_W), .CTRL_BYTES(CTRL_BYTES), .ADDR_W(HOST_AW)) u_host (
    .clk_i, .rst_ni,
    .we_i(host_we_i), .re_i(host_re_i), .addr_i(host_addr_i), .wdata_i(host_wdata_i),
    .busy_i(busy), .ring_o(ring), .cmd_o(cmd), .ctrl_o(ctrl), .rdata_o(host_rdata_o)
  );

  mbox_irq_core u_core (
    .clk_i, .rst_ni,
    .ring_i   (ring),
    .clr_i    (dsp_re_i && dsp_addr_i == DA_DOORBELL),
    .en_we_i  (dsp_we_i && dsp_addr_i == DA_IRQ),
    .en_d_i   (dsp_wdata_i[IRQ_EN_BIT]),
    .busy_we_i(dsp_we_i && dsp_addr_i == DA_BUSY),
    .busy_d_i (dsp_wdata_i[BUSY_BIT]),
    .status_o (status), .en_o(en), .busy_o(busy), .irq_o(dsp_irq_o)
  );

  always_comb begin
    d_mux = '0;
    unique case (dsp_addr_i)
      DA_DOORBELL: d_mux = DSP_W'(cmd);
      DA_IRQ: begin
        d_mux[IRQ_STAT_BIT] = status;
        d_mux[IRQ_EN_BIT]   = en;
      end
      DA_BUSY: d_mux[BUSY_BIT] = busy;
      DA_CTRL: d_mux = ctrl;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       dsp_rdata_o <= '0;
    else if (dsp_re_i) dsp_rdata_o <= d_mux;
  end

  assert_irq_off_reset_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dsp_irq_o) |-> $past(ring || (dsp_we_i && dsp_addr_i == DA_IRQ)));
endmodule

// File: tb/tb_h2d_mbox.sv
module tb_h2d_mbox;
  typedef struct packed {
    logic        h_we, h_re;
    logic [1:0]  h_a;
    logic [7:0]  h_d;
    logic        d_we, d_re;
    logic [1:0]  d_a;
    logic [15:0] d_d;
    logic        e_irq;
    logic [7:0]  e_h;
    logic [15:0] e_d;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,2'd0,8'h00, 1'b1,1'b0,2'd1,16'h0002, 1'b0,8'h00,16'h0000, 4'd5},  // R5 enable
    '{1'b1,1'b0,2'd1,8'h34, 1'b0,1'b0,2'd0,16'h0000, 1'b0,8'h00,16'h0000, 4'd6},  // R6 low byte
    '{1'b1,1'b0,2'd2,8'h12, 1'b0,1'b0,2'd0,16'h0000, 1'b0,8'h00,16'h0000, 4'd6},  // R6 high byte
    '{1'b0,1'b1,2'd2,8'h00, 1'b0,1'b1,2'd3,16'h0000, 1'b0,8'h12,16'h1234, 4'd6},  // R6 readback
    '{1'b1,1'b0,2'd0,8'hA5, 1'b0,1'b0,2'd0,16'h0000, 1'b1,8'h12,16'h1234, 4'd1},  // R1 ring
    '{1'b0,1'b1,2'd0,8'h00, 1'b0,1'b0,2'd0,16'h0000, 1'b1,8'h01,16'h1234, 4'd2},  // R2 busy seen
    '{1'b0,1'b0,2'd0,8'h00, 1'b0,1'b1,2'd1,16'h0000, 1'b1,8'h01,16'h0003, 4'd5},  // R5 status+en
    '{1'b0,1'b0,2'd0,8'h00, 1'b1,1'b0,2'd1,16'h0000, 1'b0,8'h01,16'h0003, 4'd5},  // R5 mask
    '{1'b0,1'b0,2'd0,8'h00, 1'b0,1'b1,2'd1,16'h0000, 1'b0,8'h01,16'h0001, 4'd5},  // R5 status kept
    '{1'b0,1'b0,2'd0,8'h00, 1'b1,1'b0,2'd1,16'h0002, 1'b1,8'h01,16'h0001, 4'd5},  // R5 unmask
    '{1'b0,1'b0,2'd0,8'h00, 1'b0,1'b1,2'd0,16'h0000, 1'b0,8'h01,16'h00A5, 4'd3},  // R3 read clears
    '{1'b0,1'b1,2'd0,8'h00, 1'b0,1'b1,2'd2,16'h0000, 1'b0,8'h01,16'h0001, 4'd4},  // R4 busy kept
    '{1'b0,1'b0,2'd0,8'h00, 1'b1,1'b0,2'd2,16'h0001, 1'b0,8'h01,16'h0001, 4'd4},  // R4 write 1
    '{1'b0,1'b0,2'd0,8'h00, 1'b1,1'b0,2'd2,16'h0000, 1'b0,8'h01,16'h0001, 4'd4},  // R4 release
    '{1'b0,1'b1,2'd0,8'h00, 1'b0,1'b1,2'd2,16'h0000, 1'b0,8'h00,16'h0000, 4'd4},  // R4 busy 0
    '{1'b1,1'b0,2'd0,8'h5A, 1'b0,1'b1,2'd0,16'h0000, 1'b1,8'h00,16'h00A5, 4'd7},  // R7 collision
    '{1'b0,1'b0,2'd0,8'h00, 1'b0,1'b1,2'd0,16'h0000, 1'b0,8'h00,16'h005A, 4'd3},  // R3 new byte
    '{1'b0,1'b0,2'd0,8'h00, 1'b1,1'b0,2'd2,16'h0000, 1'b0,8'h00,16'h005A, 4'd4},  // R4 idle release
    '{1'b1,1'b0,2'd0,8'h11, 1'b1,1'b0,2'd2,16'h0000, 1'b1,8'h00,16'h005A, 4'd10}, // R10 collision
    '{1'b0,1'b1,2'd0,8'h00, 1'b0,1'b1,2'd2,16'h0000, 1'b1,8'h01,16'h0001, 4'd10}  // R10 busy held
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic h_we = 0, h_re = 0, d_we = 0, d_re = 0;
  logic [1:0] h_a = '0, d_a = '0;
  logic [7:0] h_d = '0;
  logic [15:0] d_d = '0;
  logic [7:0] h_rd;
  logic [15:0] d_rd;
  logic irq;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  h2d_mbox dut (
    .clk_i(clk), .rst_ni(rst_n),
    .host_we_i(h_we), .host_re_i(h_re), .host_addr_i(h_a), .host_wdata_i(h_d),
    .host_rdata_o(h_rd),
    .dsp_we_i(d_we), .dsp_re_i(d_re), .dsp_addr_i(d_a), .dsp_wdata_i(d_d),
    .dsp_rdata_o(d_rd), .dsp_irq_o(irq)
  );

  task automatic chk(input int req, input logic e_irq, input logic [7:0] e_h,
                     input logic [15:0] e_d);
    n_chk++;
    if (irq !== e_irq || h_rd !== e_h || d_rd !== e_d) begin
      n_fail++;
      $display("FAIL R%0d: irq=%b h=%h d=%h expected irq=%b h=%h d=%h",
               req, irq, h_rd, d_rd, e_irq, e_h, e_d);
    end
  endtask

  task automatic step(input vec_t v);
    h_we = v.h_we; h_re = v.h_re; h_a = v.h_a; h_d = v.h_d;
    d_we = v.d_we; d_re = v.d_re; d_a = v.d_a; d_d = v.d_d;
    @(posedge clk); @(negedge clk);
    h_we = 0; h_re = 0; d_we = 0; d_re = 0;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    chk(8, 1'b0, 8'h00, 16'h0000);  // R8 in reset
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      step(VECS[i]);
      chk(int'(VECS[i].req), VECS[i].e_irq, VECS[i].e_h, VECS[i].e_d);
    end
    // R9 idle cycle keeps read data
    step('0);
    chk(9, 1'b1, 8'h01, 16'h0001);
    // R8 mid-run reset clears status, enable, busy, data
    rst_n = 1'b0;
    @(negedge clk);
    chk(8, 1'b0, 8'h00, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    step('{1'b0,1'b1,2'd0,8'h00, 1'b0,1'b1,2'd1,16'h0000, 1'b0,8'h00,16'h0000, 4'd8});
    chk(8, 1'b0, 8'h00, 16'h0000);
    step('{1'b0,1'b1,2'd1,8'h00, 1'b0,1'b1,2'd3,16'h0000, 1'b0,8'h00,16'h0000, 4'd8});
    chk(8, 1'b0, 8'h00, 16'h0000);
    // R1 ring while masked after reset: no irq, status visible
    step('{1'b1,1'b0,2'd0,8'h77, 1'b0,1'b0,2'd0,16'h0000, 1'b0,8'h00,16'h0000, 4'd1});
    step('{1'b0,1'b0,2'd0,8'h00, 1'b0,1'b1,2'd1,16'h0000, 1'b0,8'h00,16'h0001, 4'd1});
    chk(1, 1'b0, 8'h00, 16'h0001);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule